// File: doc/BRIEF.md
# Breakpoint Condition Table Loader

This block writes the condition tables that a breakpoint matcher reads. Each table is a single-ported synchronous RAM with one entry per bus value, and each entry holds a few flag bits. The matcher owns the tables while the processor runs. The loader may only edit them while the processor is halted with its buses released. The one exception is coverage marking, where the loader itself owns the selected tables.

An operator or a host link issues commands. The first edits a single entry by read-modify-write, at a given address or at a cursor that step pulses nudge up and down. The second fills one flag bit over an inclusive address range. The third sweeps the whole address space to flush entries. Any subset of the tables can be written in parallel. In coverage mode the loader turns every processor cycle's bus value into a set-only write of one marker bit, so the table records which values were seen.

Top module: `bpt_loader`

## Requirements
- R1: After reset `busy`, `done` and every `ram_we` bit are low and `cursor` is zero.
- R2: A command is accepted only when `cmd_valid`, `cpu_halted` and idle all hold, `cov_en` is low and `cmd_op` is a legal code (0 toggle-at-address, 1 toggle-at-cursor, 2 range fill, 3 full sweep). Any other command has no effect: no write, no `busy`, no `done`, no cursor change.
- R3: Toggle-at-address (op 0) holds `busy` for exactly 3 cycles. In the first cycle it reads `cmd_addr` with `ram_re`, and in the third it writes the inverted value of bit `cmd_bit`, with `ram_wmask` one-hot on that bit. It also loads `cursor` with `cmd_addr`.
- R4: Toggle-at-cursor (op 1) does the same read-invert-write at the current `cursor` address.
- R5: When idle, halted and not in coverage mode, a `step_up` pulse adds one to `cursor` and a `step_dn` pulse subtracts one, both wrapping modulo the address space. Both together, or either while busy, leave `cursor` unchanged.
- R6: Range fill (op 2) writes `cmd_val` into bit `cmd_bit` of every address from `cmd_addr` to `cmd_end` inclusive. It writes in ascending order, one address per clock, so `busy` lasts end-start+1 cycles.
- R7: A range fill with `cmd_addr` greater than `cmd_end` writes nothing. `done` pulses in the cycle after acceptance, and `busy` never rises.
- R8: Full sweep (op 3) writes every bit of every address from 0 to the top of the address space to `cmd_val`, one address per clock, for 2^ADDR_W cycles.
- R9: Each write of an operation reaches every table whose `cmd_tsel` bit is set, in the same cycle. A toggle inverts each table's own stored bit.
- R10: In coverage mode each cycle with `cov_strobe` high produces one write in the following cycle at address `cov_value`, to the tables in `cov_tsel`. That write sets bit `cov_bit` and leaves the other bits of the entry unchanged.
- R11: `done` is a single-cycle pulse. It is high in the first cycle after an operation's last write, when `busy` is already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_halted | input | 1 | Processor stopped with buses released |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Operation code |
| cmd_tsel | input | N_TABLES | Table select mask |
| cmd_bit | input | BIT_W | Flag bit index |
| cmd_addr | input | ADDR_W | Target or start address |
| cmd_end | input | ADDR_W | Inclusive end address of a fill |
| cmd_val | input | 1 | Bit value for fill and sweep |
| step_up | input | 1 | Cursor increment pulse |
| step_dn | input | 1 | Cursor decrement pulse |
| cov_en | input | 1 | Coverage marking mode |
| cov_strobe | input | 1 | One processor cycle observed |
| cov_tsel | input | N_TABLES | Tables marked in coverage mode |
| cov_bit | input | BIT_W | Marker bit index |
| cov_value | input | ADDR_W | Observed bus value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished pulse |
| cursor | output | ADDR_W | Edit cursor address |
| ram_addr | output | ADDR_W | Shared table address |
| ram_re | output | 1 | Read strobe |
| ram_we | output | N_TABLES | Per-table write enable |
| ram_wmask | output | DATA_W | Bit write mask |
| ram_wdata | output | N_TABLES*DATA_W | Per-table write data |
| ram_rdata | input | N_TABLES*DATA_W | Per-table read data, one cycle after read |

## Verification
A command sampled at an edge shows `busy` at the next sample point, so the bench counts busy samples and expects 3 for a toggle, the range length for a fill and 2^ADDR_W for a sweep. The `done` pulse must be present at the first sample where `busy` is low. A coverage strobe produces its write exactly one cycle later, and a cursor step is visible one cycle after the pulse. The driver queues every write it expects, in issue order, and the monitor compares each write-enable cycle against the head of the queue. Any write that arrives with nothing queued is an error, which is how ignored commands are checked.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
   typedef enum logic [2:0] {
      OP_TGL_AT  = 3'd0,
      OP_TGL_CUR = 3'd1,
      OP_FILL    = 3'd2,
      OP_SWEEP   = 3'd3
   } bpt_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_MOD,
      ST_WR,
      ST_RUN
   } bpt_state_e;
endpackage

// File: rtl/bpt_walker.sv
module bpt_walker #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] ld_start,
   input  logic [ADDR_W-1:0] ld_end,
   input  logic              adv,
   output logic [ADDR_W-1:0] addr,
   output logic              at_end
);
   logic [ADDR_W-1:0] addr_q, end_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         end_q  <= '0;
      end else if (load) begin
         addr_q <= ld_start;
         end_q  <= ld_end;
      end else if (adv) begin
         addr_q <= addr_q + ADDR_W'(1);
      end
   end

   assign addr   = addr_q;
   assign at_end = (addr_q == end_q);

   AST_WALK_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load) |=> (addr == $past(addr) + ADDR_W'(1))); // R6
endmodule

// File: rtl/bpt_cursor.sv
module bpt_cursor #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              set,
   input  logic [ADDR_W-1:0] set_val,
   input  logic              up,
   input  logic              dn,
   output logic [ADDR_W-1:0] cur
);
   logic [ADDR_W-1:0] cur_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cur_q <= '0;
      else if (set)
         cur_q <= set_val;
      else if (en && up && !dn)
         cur_q <= cur_q + ADDR_W'(1);
      else if (en && dn && !up)
         cur_q <= cur_q - ADDR_W'(1);
   end

   assign cur = cur_q;

   AST_CURSOR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !set) |=> $stable(cur)); // R5
endmodule

// File: rtl/bpt_lane.sv
module bpt_lane #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic [DATA_W-1:0] rdata,
   input  logic              sel_cov,
   input  logic              sel_inv,
   input  logic              fill_val,
   output logic [DATA_W-1:0] wdata
);
   logic [DATA_W-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hold_q <= '0;
      else if (cap)
         hold_q <= rdata;
   end

   always_comb begin
      if (sel_cov)
         wdata = '1;
      else if (sel_inv)
         wdata = ~hold_q;
      else
         wdata = {DATA_W{fill_val}};
   end
endmodule

// File: rtl/bpt_loader.sv
module bpt_loader
   import bpt_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int N_TABLES = 4,
   localparam int BIT_W   = $clog2(DATA_W)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cpu_halted,
   input  logic                       cmd_valid,
   input  logic [2:0]                 cmd_op,
   input  logic [N_TABLES-1:0]        cmd_tsel,
   input  logic [BIT_W-1:0]           cmd_bit,
   input  logic [ADDR_W-1:0]          cmd_addr,
   input  logic [ADDR_W-1:0]          cmd_end,
   input  logic                       cmd_val,
   input  logic                       step_up,
   input  logic                       step_dn,
   input  logic                       cov_en,
   input  logic                       cov_strobe,
   input  logic [N_TABLES-1:0]        cov_tsel,
   input  logic [BIT_W-1:0]           cov_bit,
   input  logic [ADDR_W-1:0]          cov_value,
   output logic                       busy,
   output logic                       done,
   output logic [ADDR_W-1:0]          cursor,
   output logic [ADDR_W-1:0]          ram_addr,
   output logic                       ram_re,
   output logic [N_TABLES-1:0]        ram_we,
   output logic [DATA_W-1:0]          ram_wmask,
   output logic [N_TABLES*DATA_W-1:0] ram_wdata,
   input  logic [N_TABLES*DATA_W-1:0] ram_rdata
);
   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
         $error("bpt_loader: ADDR_W must lie in 1..32");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("bpt_loader: DATA_W must be at least 2");
      end
      if (N_TABLES < 1) begin : g_bad_tables
         $error("bpt_loader: N_TABLES must be at least 1");
      end
   endgenerate

   bpt_state_e        state_q;
   bpt_op_e           op_in;
   logic              op_legal, accept, fill_empty, go_rmw, go_run;
   logic [ADDR_W-1:0] walk_addr, ld_start, ld_end;
   logic              walk_last;
   logic              full_q, val_q, done_q;
   logic [BIT_W-1:0]  bit_q;
   logic [N_TABLES-1:0] tsel_q;
   logic              cov_v;
   logic [ADDR_W-1:0] cov_addr_q;
   logic [BIT_W-1:0]  cov_bit_q;
   logic [N_TABLES-1:0] cov_tsel_q;
   logic              idle_ok;

   assign op_in      = bpt_op_e'(cmd_op);
   assign op_legal   = (op_in == OP_TGL_AT) || (op_in == OP_TGL_CUR) ||
                       (op_in == OP_FILL)   || (op_in == OP_SWEEP);
   assign idle_ok    = (state_q == ST_IDLE) && cpu_halted && !cov_en;
   assign accept     = cmd_valid && idle_ok && op_legal;
   assign fill_empty = (op_in == OP_FILL) && (cmd_addr > cmd_end);
   assign go_rmw     = accept && ((op_in == OP_TGL_AT) || (op_in == OP_TGL_CUR));
   assign go_run     = accept && ((op_in == OP_SWEEP) ||
                                  ((op_in == OP_FILL) && !fill_empty));

   always_comb begin
      case (op_in)
         OP_TGL_CUR: begin ld_start = cursor;   ld_end = cursor;   end
         OP_SWEEP:   begin ld_start = '0;       ld_end = '1;       end
         default:    begin ld_start = cmd_addr; ld_end = cmd_end;  end
      endcase
   end

   bpt_walker #(.ADDR_W(ADDR_W)) u_walk (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .ld_start (ld_start),
      .ld_end   (ld_end),
      .adv      (state_q == ST_RUN),
      .addr     (walk_addr),
      .at_end   (walk_last)
   );

   bpt_cursor #(.ADDR_W(ADDR_W)) u_cur (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (idle_ok),
      .set     (accept && (op_in == OP_TGL_AT)),
      .set_val (cmd_addr),
      .up      (step_up),
      .dn      (step_dn),
      .cur     (cursor)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
         full_q  <= 1'b0;
         val_q   <= 1'b0;
         bit_q   <= '0;
         tsel_q  <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  full_q <= (op_in == OP_SWEEP);
                  val_q  <= cmd_val;
                  bit_q  <= cmd_bit;
                  tsel_q <= cmd_tsel;
                  if (go_rmw)
                     state_q <= ST_RD;
                  else if (go_run)
                     state_q <= ST_RUN;
                  else
                     done_q <= 1'b1;
               end
            end
            ST_RD:  state_q <= ST_MOD;
            ST_MOD: state_q <= ST_WR;
            ST_WR: begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
            end
            ST_RUN: begin
               if (walk_last) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cov_v      <= 1'b0;
         cov_addr_q <= '0;
         cov_bit_q  <= '0;
         cov_tsel_q <= '0;
      end else begin
         cov_v      <= cov_en && cov_strobe && (state_q == ST_IDLE);
         cov_addr_q <= cov_value;
         cov_bit_q  <= cov_bit;
         cov_tsel_q <= cov_tsel;
      end
   end

   logic seq_wr;
   assign seq_wr = (state_q == ST_WR) || (state_q == ST_RUN);

   assign busy     = (state_q != ST_IDLE);
   assign done     = done_q;
   assign ram_re   = (state_q == ST_RD);
   assign ram_addr = cov_v ? cov_addr_q : walk_addr;

   always_comb begin
      if (cov_v)
         ram_we = cov_tsel_q;
      else if (seq_wr)
         ram_we = tsel_q;
      else
         ram_we = '0;
   end

   always_comb begin
      if (cov_v)
         ram_wmask = DATA_W'(1) << cov_bit_q;
      else if (full_q)
         ram_wmask = '1;
      else
         ram_wmask = DATA_W'(1) << bit_q;
   end

   for (genvar t = 0; t < N_TABLES; t++) begin : g_lane
      bpt_lane #(.DATA_W(DATA_W)) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .cap      (state_q == ST_MOD),
         .rdata    (ram_rdata[t*DATA_W +: DATA_W]),
         .sel_cov  (cov_v),
         .sel_inv  (state_q == ST_WR),
         .fill_val (val_q),
         .wdata    (ram_wdata[t*DATA_W +: DATA_W])
      );
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R11
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R11
   AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ram_re |-> (ram_we == '0)); // R3
   AST_READ_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      ram_re |=> (busy && !ram_re && ram_we == '0)); // R3
   AST_COV_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && ram_we != '0) |-> $onehot(ram_wmask)); // R10
   AST_IDLE_UNHALTED: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cpu_halted && !cmd_valid) |=> !busy); // R2
endmodule

// File: tb/sim_bpt_loader.sv
module sim_bpt_loader;
   localparam int AW = 8;
   localparam int DW = 8;
   localparam int NT = 2;
   localparam int BW = $clog2(DW);
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_halted = 1'b1;
   logic cmd_valid = 1'b0;
   logic [2:0] cmd_op = '0;
   logic [NT-1:0] cmd_tsel = '0;
   logic [BW-1:0] cmd_bit = '0;
   logic [AW-1:0] cmd_addr = '0, cmd_end = '0;
   logic cmd_val = 1'b0;
   logic step_up = 1'b0, step_dn = 1'b0;
   logic cov_en = 1'b0, cov_strobe = 1'b0;
   logic [NT-1:0] cov_tsel = '0;
   logic [BW-1:0] cov_bit = '0;
   logic [AW-1:0] cov_value = '0;
   logic busy, done, ram_re;
   logic [AW-1:0] cursor, ram_addr;
   logic [NT-1:0] ram_we;
   logic [DW-1:0] ram_wmask;
   logic [NT*DW-1:0] ram_wdata;
   logic [NT*DW-1:0] ram_rdata = '0;

   always #2 clk = ~clk;

   bpt_loader #(.ADDR_W(AW), .DATA_W(DW), .N_TABLES(NT)) u0 (.*);

   logic [DW-1:0] mem    [NT][DEPTH];
   logic [DW-1:0] shadow [NT][DEPTH];

   always_ff @(posedge clk) begin
      for (int t = 0; t < NT; t++) begin
         if (ram_re) ram_rdata[t*DW +: DW] <= mem[t][ram_addr];
         if (ram_we[t])
            mem[t][ram_addr] <= (mem[t][ram_addr] & ~ram_wmask) |
                                (ram_wdata[t*DW +: DW] & ram_wmask);
      end
   end

   typedef struct packed {
      logic [NT-1:0]    we;
      logic [AW-1:0]    addr;
      logic [DW-1:0]    mask;
      logic [NT*DW-1:0] data;
   } wr_item_t;

   wr_item_t exp_q[$];
   string    tag_q[$];
   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   // monitor: every write cycle is compared with the head of the queue
   always @(negedge clk) begin
      if (rst_n && ram_we != '0) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R2", "unexpected write addr", longint'(ram_addr), 0);
         end else begin
            wr_item_t e;
            string r;
            bit ok;
            e = exp_q.pop_front();
            r = tag_q.pop_front();
            ok = (ram_we == e.we) && (ram_addr == e.addr) && (ram_wmask == e.mask);
            for (int t = 0; t < NT; t++)
               if (e.we[t] && ((ram_wdata[t*DW +: DW] & e.mask) != (e.data[t*DW +: DW] & e.mask)))
                  ok = 0;
            check(ok, r, "write {we,addr,mask,data}",
                  longint'({ram_we, ram_addr, ram_wmask, ram_wdata}),
                  longint'({e.we, e.addr, e.mask, e.data}));
         end
      end
   end

   initial begin
      for (int i = 0; i < 150000; i++) @(posedge clk);
      check(1'b0, "WATCHDOG", "timeout", 0, 0);
      summary();
   end

   task automatic push(input logic [NT-1:0] we, input logic [AW-1:0] a,
                       input logic [DW-1:0] m, input logic [NT*DW-1:0] d,
                       input string r);
      wr_item_t e;
      e.we = we; e.addr = a; e.mask = m; e.data = d;
      exp_q.push_back(e);
      tag_q.push_back(r);
      for (int t = 0; t < NT; t++)
         if (we[t]) shadow[t][a] = (shadow[t][a] & ~m) | (d[t*DW +: DW] & m);
   endtask

   task automatic issue(input logic [2:0] op, input logic [NT-1:0] ts,
                        input logic [BW-1:0] b, input logic [AW-1:0] a,
                        input logic [AW-1:0] e, input logic v);
      @(negedge clk);
      cmd_op = op; cmd_tsel = ts; cmd_bit = b; cmd_addr = a; cmd_end = e; cmd_val = v;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic finish_op(input int exp_busy, input string r);
      int n = 0;
      while (busy) begin
         n++;
         @(negedge clk);
      end
      check(n == exp_busy, r, "busy cycles", n, exp_busy);
      check(done == 1'b1, "R11", "done at first idle sample", done, 1);
      @(negedge clk);
      check(done == 1'b0, "R11", "done single cycle", done, 0);
   endtask

   task automatic toggle_exp(input logic [NT-1:0] ts, input logic [BW-1:0] b,
                             input logic [AW-1:0] a, input string r);
      logic [NT*DW-1:0] d;
      for (int t = 0; t < NT; t++) d[t*DW +: DW] = ~shadow[t][a];
      push(ts, a, DW'(1) << b, d, r);
   endtask

   task automatic idle_quiet(input string r);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(!busy && !done, r, "ignored command left busy/done", {busy, done}, 0);
      end
   endtask

   initial begin
      for (int t = 0; t < NT; t++)
         for (int a = 0; a < DEPTH; a++) begin
            mem[t][a]    = DW'(a * 7 + t * 3);
            shadow[t][a] = DW'(a * 7 + t * 3);
         end
      repeat (3) @(negedge clk);
      check(!busy && !done && ram_we == '0 && cursor == '0, "R1", "reset outputs",
            {busy, done, ram_we, cursor}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && ram_we == '0, "R1", "idle after reset", {busy, done, ram_we}, 0);

      // R3 toggle at address
      toggle_exp(2'b01, 3, 8'h10, "R3");
      issue(3'd0, 2'b01, 3, 8'h10, 8'h00, 1'b0);
      check(ram_re && ram_addr == 8'h10, "R3", "read first cycle", {ram_re, ram_addr}, {1'b1, 8'h10});
      check(cursor == 8'h10, "R3", "cursor loaded", cursor, 8'h10);
      finish_op(3, "R3");

      // R5 steps
      step_up = 1; @(negedge clk); step_up = 0;
      check(cursor == 8'h11, "R5", "step up", cursor, 8'h11);
      step_dn = 1; @(negedge clk); @(negedge clk); step_dn = 0;
      check(cursor == 8'h0F, "R5", "step down twice", cursor, 8'h0F);
      step_up = 1; step_dn = 1; @(negedge clk); step_up = 0; step_dn = 0;
      check(cursor == 8'h0F, "R5", "both steps no change", cursor, 8'h0F);

      // R4 toggle at cursor, R9 both tables
      toggle_exp(2'b11, 0, 8'h0F, "R4_R9");
      issue(3'd1, 2'b11, 0, 8'hAA, 8'h00, 1'b0);
      finish_op(3, "R4");

      // R6 range fill
      for (int a = 8'h20; a <= 8'h2F; a++) push(2'b10, AW'(a), 8'h20, {NT*DW{1'b1}}, "R6");
      issue(3'd2, 2'b10, 5, 8'h20, 8'h2F, 1'b1);
      finish_op(16, "R6");

      // R7 empty range
      issue(3'd2, 2'b11, 1, 8'h30, 8'h2F, 1'b1);
      finish_op(0, "R7");

      // R6 single-entry range
      push(2'b11, 8'h40, 8'h80, '0, "R6");
      issue(3'd2, 2'b11, 7, 8'h40, 8'h40, 1'b0);
      finish_op(1, "R6");

      // R2 ignored: not halted, illegal op
      cpu_halted = 1'b0;
      issue(3'd3, 2'b11, 0, 8'h00, 8'h00, 1'b1);
      check(!busy, "R2", "not halted accepted", busy, 0);
      idle_quiet("R2");
      cpu_halted = 1'b1;
      issue(3'd6, 2'b11, 0, 8'h00, 8'hFF, 1'b1);
      check(!busy, "R2", "illegal op accepted", busy, 0);
      idle_quiet("R2");

      // R8 sweep, with a command and a step arriving mid-sweep
      for (int a = 0; a < DEPTH; a++) push(2'b01, AW'(a), 8'hFF, '0, "R8");
      issue(3'd3, 2'b01, 0, 8'h55, 8'h11, 1'b0);
      repeat (20) @(negedge clk);
      cmd_op = 3'd0; cmd_tsel = 2'b11; cmd_addr = 8'h77; cmd_valid = 1'b1; step_up = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0; step_up = 1'b0;
      finish_op(DEPTH - 21, "R8");
      check(cursor == 8'h0F, "R5", "cursor frozen while busy", cursor, 8'h0F);

      // R5 wrap at zero
      toggle_exp(2'b10, 2, 8'h00, "R3");
      issue(3'd0, 2'b10, 2, 8'h00, 8'h00, 1'b0);
      finish_op(3, "R3");
      step_dn = 1; @(negedge clk); step_dn = 0;
      check(cursor == 8'hFF, "R5", "step down wraps", cursor, 8'hFF);

      // R10 coverage marking
      @(negedge clk);
      cov_en = 1'b1; cov_tsel = 2'b11; cov_bit = 2;
      foreach (cov_vals[i]) begin
         push(2'b11, cov_vals[i], 8'h04, {NT*DW{1'b1}}, "R10");
         cov_value = cov_vals[i]; cov_strobe = 1'b1;
         @(negedge clk);
      end
      cov_strobe = 1'b0;
      @(negedge clk);
      cmd_op = 3'd3; cmd_tsel = 2'b11; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      check(!busy, "R2", "command during coverage", busy, 0);
      cov_en = 1'b0;
      repeat (4) @(negedge clk);

      check(exp_q.size() == 0, "R10", "writes outstanding", exp_q.size(), 0);
      begin
         int bad = 0;
         for (int t = 0; t < NT; t++)
            for (int a = 0; a < DEPTH; a++)
               if (mem[t][a] !== shadow[t][a]) bad++;
         check(bad == 0, "R10", "table contents mismatching entries", bad, 0);
      end
      summary();
   end

   logic [AW-1:0] cov_vals [4] = '{8'h05, 8'h05, 8'hFF, 8'h20};
endmodule